// File: doc/BRIEF.md
# Power-Up Clock Source Selector

This block picks the master clock for a converter core each time the device leaves power-down. The always-present internal oscillator clocks the block itself. A candidate external clock pin is passed through a synchronizer, and its rising edges are counted over a fixed window of internal-oscillator cycles. If the count shows the pin toggling faster than a frequency threshold, 300 kHz by default, the block selects the external source. In that case it waits a configurable start-up interval, which allows a crystal to stabilise, and then disables the internal oscillator. A pin that is grounded or too slow leaves the internal oscillator in charge.

The decision is made once per wake-up. After the ready strobe rises, the selection is frozen and the external pin is ignored until the power-down input is asserted and released again. The clock multiplexer itself is represented by the selection flag and the ready strobe. The analog crystal driver and the oscillator are outside this block.

Top module: `clk_src_picker`

## Requirements
- R1: While `pwr_dn_n` is low, `clk_ready` is 0, `use_ext` is 0 and `osc_en` is 1.
- R2: With the external pin held at 0, the block settles with `use_ext`=0 and `osc_en`=1.
- R3: The edge limit is floor(EXT_MIN_HZ*WIN_CYCLES/OSC_HZ), which is 62 with the defaults. If more rising edges than this limit are counted in the window, `use_ext` becomes 1.
- R4: If the counted rising edges are at or below the edge limit, `use_ext` stays 0.
- R5: When the internal source is chosen, `clk_ready` rises after exactly WIN_CYCLES+1 rising clock edges counted from the release of `pwr_dn_n`.
- R6: When the external source is chosen, `clk_ready` rises after exactly WIN_CYCLES+1+XTAL_WAIT edges. During the wait, `use_ext` is already 1 while `osc_en` stays 1. `osc_en` falls in the same cycle that `clk_ready` rises.
- R7: Once `clk_ready` is 1, it stays 1 and neither `use_ext` nor `osc_en` changes until the next power-down, whatever the external pin does.
- R8: Each release of `pwr_dn_n` runs a fresh measurement, so a new decision can differ from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock; clocks the whole block |
| pwr_dn_n | input | 1 | Active-low power-down; clears the decision asynchronously |
| ext_pin | input | 1 | Candidate external clock pin, asynchronous |
| use_ext | output | 1 | 1 selects the external clock as master |
| osc_en | output | 1 | Enable for the internal oscillator |
| clk_ready | output | 1 | Selected clock is valid and stable |

## Verification
The assertions check three things on every cycle:
- the ready strobe stays high once raised, and the selection holds still while it is high;
- the oscillator enable drops only after the external source is selected and ready;
- the verdict inside the edge meter stays fixed once its window has closed.

Only the bench scenarios can show two further properties. First, that a given toggle rate lands on the correct side of the edge limit. Second, that the strobe appears after exactly the expected number of edges for each source. These scenarios use a grounded pin and both fast and slow pin rates, some directed and some drawn at random. They also cover pin activity after lock and repeated wake-ups with changing verdicts.

// File: rtl/ck_sel_pkg.sv
`timescale 1ns/1ps
package ck_sel_pkg;
    typedef enum logic [1:0] {
        SEL_MEASURE = 2'd0,
        SEL_SETTLE  = 2'd1,
        SEL_LOCKED  = 2'd2
    } sel_state_e;

    function automatic int unsigned edge_limit(input int unsigned min_hz,
                                               input int unsigned win,
                                               input int unsigned osc_hz);
        longint unsigned prod;
        prod = longint'(min_hz) * longint'(win);
        return int'(prod / longint'(osc_hz));
    endfunction
endpackage

// File: rtl/ck_sync.sv
`timescale 1ns/1ps
module ck_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ck_edge_meter.sv
`timescale 1ns/1ps
module ck_edge_meter #(
    parameter int unsigned WIN   = 1024,
    parameter int unsigned LIMIT = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic done,
    output logic fast
);
    localparam int unsigned WW = $clog2(WIN + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [WW-1:0] cnt;
        logic          prev;
        logic          done;
        logic          fast;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (!m_q.done) begin
            m_d.win = m_q.win + 1'b1;
            if (lvl && !m_q.prev) m_d.cnt = m_q.cnt + 1'b1;
            if (m_q.win == WW'(WIN - 1)) begin
                m_d.done = 1'b1;
                m_d.fast = (m_d.cnt > WW'(LIMIT));
            end
        end
        m_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign done = m_q.done;
    assign fast = m_q.fast;

    // R3: the verdict is fixed once the window closes
    assert_verdict_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(fast)));
endmodule

// File: rtl/clk_src_picker.sv
`timescale 1ns/1ps
module clk_src_picker #(
    parameter int unsigned OSC_HZ     = 4_915_200,
    parameter int unsigned EXT_MIN_HZ = 300_000,
    parameter int unsigned WIN_CYCLES = 1024,
    parameter int unsigned XTAL_WAIT  = 27_525,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic pwr_dn_n,
    input  logic ext_pin,
    output logic use_ext,
    output logic osc_en,
    output logic clk_ready
);
    import ck_sel_pkg::*;

    localparam int unsigned LIMIT    = edge_limit(EXT_MIN_HZ, WIN_CYCLES, OSC_HZ);
    localparam bit          HAS_WAIT = (XTAL_WAIT > 0);
    localparam int unsigned DW       = (XTAL_WAIT > 1) ? $clog2(XTAL_WAIT + 1) : 1;

    typedef struct packed {
        sel_state_e    st;
        logic          ext;
        logic [DW-1:0] dly;
    } pick_t;

    pick_t p_d, p_q;
    logic  ext_sync;
    logic  meter_done;
    logic  meter_fast;
    logic  settle_end;

    ck_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (osc_clk),
        .rst_n (pwr_dn_n),
        .d     (ext_pin),
        .q     (ext_sync)
    );

    ck_edge_meter #(.WIN(WIN_CYCLES), .LIMIT(LIMIT)) meter_i (
        .clk   (osc_clk),
        .rst_n (pwr_dn_n),
        .lvl   (ext_sync),
        .done  (meter_done),
        .fast  (meter_fast)
    );

    generate
        if (HAS_WAIT) begin : g_wait
            assign settle_end = (p_q.dly == DW'(XTAL_WAIT - 1));
        end else begin : g_nowait
            assign settle_end = 1'b1;
        end
    endgenerate

    always_comb begin
        p_d = p_q;
        case (p_q.st)
            SEL_MEASURE: begin
                if (meter_done) begin
                    p_d.ext = meter_fast;
                    p_d.dly = '0;
                    p_d.st  = (meter_fast && HAS_WAIT) ? SEL_SETTLE : SEL_LOCKED;
                end
            end
            SEL_SETTLE: begin
                p_d.dly = p_q.dly + 1'b1;
                if (settle_end) p_d.st = SEL_LOCKED;
            end
            SEL_LOCKED: p_d = p_q;
            default:    p_d.st = SEL_MEASURE;
        endcase
    end

    always_ff @(posedge osc_clk or negedge pwr_dn_n) begin
        if (!pwr_dn_n) p_q <= '{st: SEL_MEASURE, ext: 1'b0, dly: '0};
        else           p_q <= p_d;
    end

    assign use_ext   = p_q.ext;
    assign clk_ready = (p_q.st == SEL_LOCKED);
    assign osc_en    = !(p_q.ext && clk_ready);

    // R7: ready is sticky and the choice holds while ready
    assert_ready_sticky_R7: assert property (@(posedge osc_clk) disable iff (!pwr_dn_n)
        clk_ready |=> clk_ready);
    assert_choice_frozen_R7: assert property (@(posedge osc_clk) disable iff (!pwr_dn_n)
        clk_ready |=> ($stable(use_ext) && $stable(osc_en)));
    // R6: oscillator is switched off only for a ready external choice
    assert_osc_off_gate_R6: assert property (@(posedge osc_clk) disable iff (!pwr_dn_n)
        !osc_en |-> (use_ext && clk_ready));
    // R6: settling happens only on the external path, with the oscillator still on
    assert_settle_ext_R6: assert property (@(posedge osc_clk) disable iff (!pwr_dn_n)
        (p_q.st == SEL_SETTLE) |-> (use_ext && osc_en && !clk_ready));
    // R3/R4: the selection flag follows the meter verdict when it is taken
    assert_take_verdict_R3: assert property (@(posedge osc_clk) disable iff (!pwr_dn_n)
        (p_q.st == SEL_MEASURE && meter_done) |=> (use_ext == $past(meter_fast)));
endmodule

// File: tb/clk_src_picker_tb.sv
`timescale 1ns/1ps
module clk_src_picker_tb_top;
    localparam int unsigned OSC  = 4_915_200;
    localparam int unsigned MINF = 300_000;
    localparam int unsigned WIN  = 1024;
    localparam int unsigned XW   = 300;
    localparam int unsigned THR  = (MINF * 64'(WIN)) / OSC;

    logic clk = 1'b0;
    logic pwr_dn_n = 1'b1;
    logic ext_pin = 1'b0;
    logic use_ext, osc_en, clk_ready;
    int   half = 0;
    int   ph = 0;
    int   errors = 0;
    int   checks = 0;

    always #2 clk = ~clk;

    clk_src_picker #(.OSC_HZ(OSC), .EXT_MIN_HZ(MINF), .WIN_CYCLES(WIN),
                     .XTAL_WAIT(XW)) dut_i (
        .osc_clk(clk), .pwr_dn_n(pwr_dn_n), .ext_pin(ext_pin),
        .use_ext(use_ext), .osc_en(osc_en), .clk_ready(clk_ready));

    always @(negedge clk) begin
        if (half == 0) begin
            ext_pin <= 1'b0; ph <= 0;
        end else if (ph + 1 >= half) begin
            ext_pin <= ~ext_pin; ph <= 0;
        end else begin
            ph <= ph + 1;
        end
    end

    function automatic bit want_ext(input int h);
        if (h == 0) return 1'b0;
        return (WIN / (2 * h)) > THR;
    endfunction

    function automatic bit clear_side(input int h);
        int e;
        if (h == 0) return 1'b1;
        e = WIN / (2 * h);
        return (e - 1 > int'(THR)) || (e + 1 <= int'(THR));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    bit prev_ext = 1'b0;
    bit have_prev = 1'b0;

    task automatic trial(input int h);
        bit exp_ext;
        int n;
        int exp_n;
        bit settle_ok;
        bit moved;
        exp_ext = want_ext(h);
        @(negedge clk);
        pwr_dn_n = 1'b0;
        half = h;
        repeat (6) @(negedge clk);
        chk(clk_ready == 0 && use_ext == 0 && osc_en == 1, "R1 pd outputs",
            {29'd0, clk_ready, use_ext, osc_en}, 1);
        pwr_dn_n = 1'b1;
        n = 0;
        settle_ok = 1'b1;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (exp_ext && n == int'(WIN) + 2)
                settle_ok = (use_ext == 1 && osc_en == 1 && clk_ready == 0);
        end while (!clk_ready && n < int'(WIN + XW) + 100);
        exp_n = int'(WIN) + 1 + (exp_ext ? int'(XW) : 0);
        if (exp_ext) begin
            chk(use_ext == 1, "R3 fast pin selects ext", use_ext, 1);
            chk(n == exp_n, "R6 ready latency ext", n, exp_n);
            chk(osc_en == 0, "R6 osc off at ready", osc_en, 0);
            chk(settle_ok, "R6 settle window state", settle_ok, 1);
        end else begin
            chk(use_ext == 0, (h == 0) ? "R2 grounded pin internal" : "R4 slow pin internal",
                use_ext, 0);
            chk(n == exp_n, "R5 ready latency int", n, exp_n);
            chk(osc_en == 1, "R2 osc kept on", osc_en, 1);
        end
        if (have_prev && prev_ext != exp_ext)
            chk(use_ext == exp_ext, "R8 new decision after wake", use_ext, exp_ext);
        prev_ext = exp_ext;
        have_prev = 1'b1;
        half = exp_ext ? 0 : 2;
        moved = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (use_ext != exp_ext || clk_ready != 1 || osc_en != !exp_ext) moved = 1'b1;
        end
        chk(!moved, "R7 frozen after lock", moved, 0);
    endtask

    initial begin
        int h;
        void'($urandom(32'h5eed_c10c));
        #1 pwr_dn_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_ready == 0 && use_ext == 0 && osc_en == 1, "R1 reset state",
            {29'd0, clk_ready, use_ext, osc_en}, 1);
        trial(0);    // R2 grounded
        trial(2);    // R3 well above
        trial(9);    // R4 just below
        trial(8);    // R3 just above
        trial(16);   // R4 slow
        for (int k = 0; k < 5; k++) begin
            do h = int'($urandom_range(1, 40)); while (!clear_side(h));
            trial(h);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule